// File: doc/BRIEF.md
# Four-State Driver Level Ramp Generator

This block turns a four-valued logic input into a digital level code and an output-impedance code for a converter-style back end. When the input changes, a small controller picks one of three named states. **STEADY** holds a fixed level. **RISING** and **FALLING** step the level linearly from one nominal value to another, over a set number of clock cycles. Changes into or out of the high-impedance value skip the ramp and take effect at once.

A ramp always starts from the nominal level of the state being left, not from whatever the output shows at that moment. It ends at the nominal level of the new state. Time is counted in clock cycles. The rise length and the fall length are separate parameters.

The transitions are named as follows:
- **T_HOLD**: no input change; a STEADY controller stays STEADY.
- **T_SNAP**: any change that involves Z goes to STEADY.
- **T_DOWN**: a change from 1 or X to 0 goes to FALLING.
- **T_UP**: every other change goes to RISING.
- **T_STEP**: a ramping controller with no input change advances its counter.
- **T_DONE**: a ramping controller goes to STEADY once its length has elapsed.
- **T_RESTART**: an input change during a ramp starts a fresh ramp at once.

Top module: `level_ramp_driver`

## Requirements
- R1: After reset, status is STEADY (2'b00), level is 0 and the impedance code is 0. Reset treats the held input as logic 0.
- R2: The input encoding is 2'b00 = 0, 2'b01 = 1, 2'b10 = X and 2'b11 = Z. With LW = 8, the steady levels are 0 for logic 0, 255 for logic 1, 128 for X and 0 for Z.
- R3: A change where the old or the new value is Z gives STEADY with the new nominal level. This shows one cycle after the clock edge that samples the change.
- R4: A change from 1 or from X to 0 gives status FALLING (2'b10) and uses the fall length FALL_CYC.
- R5: Any other change that does not involve Z gives status RISING (2'b01) and uses the rise length RISE_CYC. This includes 1 to X and X to 1.
- R6: Let k be the number of clock edges since the edge that sampled the change, with k = 0 on the cycle that edge produces, and let D be the applicable length. For k = 0 to D-1, the level is start + trunc((end - start) * k / D), where trunc rounds toward zero. Here start is the old nominal level and end is the new one.
- R7: At k = D, the status returns to STEADY and the level equals the new nominal level.
- R8: The impedance code is 0 (low, about 1 kΩ) for a steady 0 or 1, and 1 (medium, about 100 kΩ) for a steady X. It is 2 (high, about 1 GΩ) for a steady Z. It is 1 throughout any ramp.
- R9: An input change during a ramp restarts at once. The new ramp starts from the nominal level of the value held just before this change, not from the current output.
- R10: With no input change, a STEADY status stays STEADY and the level does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| logic_in | input | 2 | Four-valued logic input (0, 1, X, Z encoding in R2) |
| level | output | LW | Output level code |
| imp_code | output | 2 | Output impedance code |
| status | output | 2 | Controller state: 0 STEADY, 1 RISING, 2 FALLING |

## Verification
The bench builds the block with RISE_CYC = 5 and FALL_CYC = 3. These lengths are short enough that every step of every ramp can be compared against the arithmetic formula. Because the two lengths differ, selecting the wrong one is visible. With these values, all sixteen old/new input pairs are swept from a settled start. This covers the Z snaps, the 1-to-X and X-to-1 rising cases, and ramps whose scaled product does not divide evenly. A separate sequence reverses direction in the middle of a rise to exercise the restart rule.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
    typedef enum logic [1:0] {
        LV_0 = 2'b00,
        LV_1 = 2'b01,
        LV_X = 2'b10,
        LV_Z = 2'b11
    } lv_t;

    typedef enum logic [1:0] {
        ST_STEADY = 2'b00,
        ST_RISE   = 2'b01,
        ST_FALL   = 2'b10
    } st_t;

    localparam logic [1:0] IMP_LOW  = 2'd0;
    localparam logic [1:0] IMP_MID  = 2'd1;
    localparam logic [1:0] IMP_HIGH = 2'd2;
endpackage

// File: rtl/ldr_nominal.sv
module ldr_nominal
    import ldr_pkg::*;
#(
    parameter int LW = 8
) (
    input  lv_t           val,
    output logic [LW-1:0] lvl
);
    localparam logic [LW-1:0] FULL = {LW{1'b1}};
    localparam logic [LW-1:0] HALF = LW'(1) << (LW - 1);

    always_comb begin
        unique case (val)
            LV_1:    lvl = FULL;
            LV_X:    lvl = HALF;
            default: lvl = '0;
        endcase
    end
endmodule

// File: rtl/ldr_decide.sv
module ldr_decide
    import ldr_pkg::*;
(
    input  lv_t old_v,
    input  lv_t new_v,
    output st_t next_st
);
    always_comb begin
        if (old_v == LV_Z || new_v == LV_Z)
            next_st = ST_STEADY;                       // T_SNAP
        else if ((old_v == LV_1 || old_v == LV_X) && new_v == LV_0)
            next_st = ST_FALL;                         // T_DOWN
        else
            next_st = ST_RISE;                         // T_UP
    end
endmodule

// File: rtl/ldr_interp.sv
module ldr_interp
    import ldr_pkg::*;
#(
    parameter int LW       = 8,
    parameter int CW       = 4,
    parameter int RISE_CYC = 10,
    parameter int FALL_CYC = 10
) (
    input  st_t           st,
    input  logic [LW-1:0] start_lvl,
    input  logic [LW-1:0] end_lvl,
    input  logic [CW-1:0] cnt,
    output logic [LW-1:0] ramp_lvl
);
    localparam int PW = LW + CW + 3;

    logic signed [PW-1:0] diff;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] dur;
    logic signed [PW-1:0] quo;
    logic signed [PW-1:0] sum;

    always_comb begin
        diff = $signed(PW'(end_lvl)) - $signed(PW'(start_lvl));
        prod = diff * $signed(PW'(cnt));
        dur  = (st == ST_FALL) ? $signed(PW'(FALL_CYC)) : $signed(PW'(RISE_CYC));
        quo  = prod / dur;
        sum  = $signed(PW'(start_lvl)) + quo;
        ramp_lvl = sum[LW-1:0];
    end
endmodule

// File: rtl/level_ramp_driver.sv
module level_ramp_driver
    import ldr_pkg::*;
#(
    parameter int LW       = 8,
    parameter int RISE_CYC = 10,
    parameter int FALL_CYC = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    logic_in,
    output logic [LW-1:0] level,
    output logic [1:0]    imp_code,
    output logic [1:0]    status
);
    localparam int MAXD = (RISE_CYC > FALL_CYC) ? RISE_CYC : FALL_CYC;
    localparam int CW   = (MAXD < 2) ? 1 : $clog2(MAXD);
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CYC - 1);
    localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);

    lv_t           in_v;
    lv_t           cur_q, cur_d;
    st_t           st_q, st_d, dec_st;
    logic [LW-1:0] start_q, start_d, end_q, end_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [LW-1:0] nom_old, nom_new, ramp_lvl;
    logic          change;

    assign in_v   = lv_t'(logic_in);
    assign change = (in_v != cur_q);

    ldr_nominal #(.LW(LW)) u_nom_old (.val(cur_q), .lvl(nom_old));
    ldr_nominal #(.LW(LW)) u_nom_new (.val(in_v),  .lvl(nom_new));

    ldr_decide u_dec (.old_v(cur_q), .new_v(in_v), .next_st(dec_st));

    ldr_interp #(
        .LW(LW), .CW(CW), .RISE_CYC(RISE_CYC), .FALL_CYC(FALL_CYC)
    ) u_interp (
        .st(st_q), .start_lvl(start_q), .end_lvl(end_q),
        .cnt(cnt_q), .ramp_lvl(ramp_lvl)
    );

    // next-state logic
    always_comb begin
        cur_d   = cur_q;
        st_d    = st_q;
        start_d = start_q;
        end_d   = end_q;
        cnt_d   = cnt_q;
        if (change) begin                              // T_SNAP / T_UP / T_DOWN / T_RESTART
            cur_d   = in_v;
            st_d    = dec_st;
            start_d = nom_old;
            end_d   = nom_new;
            cnt_d   = '0;
        end else begin
            unique case (st_q)
                ST_STEADY: st_d = ST_STEADY;           // T_HOLD
                ST_RISE: begin
                    if (cnt_q == RISE_LAST) st_d = ST_STEADY;   // T_DONE
                    else cnt_d = cnt_q + 1'b1;                  // T_STEP
                end
                ST_FALL: begin
                    if (cnt_q == FALL_LAST) st_d = ST_STEADY;   // T_DONE
                    else cnt_d = cnt_q + 1'b1;                  // T_STEP
                end
                default: st_d = ST_STEADY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= LV_0;
            st_q    <= ST_STEADY;
            start_q <= '0;
            end_q   <= '0;
            cnt_q   <= '0;
        end else begin
            cur_q   <= cur_d;
            st_q    <= st_d;
            start_q <= start_d;
            end_q   <= end_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        status = st_q;
        unique case (st_q)
            ST_RISE, ST_FALL: begin
                level    = ramp_lvl;
                imp_code = (cur_q == LV_Z) ? IMP_HIGH : IMP_MID;
            end
            default: begin
                level = end_q;
                unique case (cur_q)
                    LV_Z:    imp_code = IMP_HIGH;
                    LV_X:    imp_code = IMP_MID;
                    default: imp_code = IMP_LOW;
                endcase
            end
        endcase
    end

    assert_hold_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STEADY && !change) |=> (st_q == ST_STEADY && $stable(level)));

    assert_z_snap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (change && (in_v == LV_Z || cur_q == LV_Z)) |=> (status == 2'b00));

    assert_ramp_mid_imp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_STEADY) |-> (imp_code == IMP_MID));

    assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FALL) |-> (cnt_q <= FALL_LAST));

    assert_fall_from_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (change && in_v == LV_0 && (cur_q == LV_1 || cur_q == LV_X)) |=> (status == 2'b10));
endmodule

// File: tb/sim_level_ramp_driver.sv
module sim_level_ramp_driver;
    localparam int LW = 8;
    localparam int RC = 5;
    localparam int FC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    din = 2'b00;
    logic [LW-1:0] level;
    logic [1:0]    imp_code;
    logic [1:0]    status;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    level_ramp_driver #(.LW(LW), .RISE_CYC(RC), .FALL_CYC(FC)) u0 (
        .clk(clk), .rst_n(rst_n), .logic_in(din),
        .level(level), .imp_code(imp_code), .status(status)
    );

    function automatic int nomv(input int v);
        case (v)
            1: return 255;
            2: return 128;
            default: return 0;
        endcase
    endfunction

    function automatic int stimp(input int v);
        case (v)
            3: return 2;
            2: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int expst(input int o, input int n);
        if (o == n || o == 3 || n == 3) return 0;
        if ((o == 1 || o == 2) && n == 0) return 2;
        return 1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // checks ramp from old o to new n, first sample is k=0
    task automatic watch(input int o, input int n);
        int s = expst(o, n);
        int d = (s == 2) ? FC : RC;
        if (s == 0) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk("R3/R10 status", status, 0);
                chk("R2/R3 level", level, nomv(n));
                chk("R8 imp", imp_code, stimp(n));
            end
        end else begin
            for (int k = 0; k <= d; k++) begin
                @(negedge clk);
                if (k < d) begin
                    chk(s == 2 ? "R4 status" : "R5 status", status, s);
                    chk("R6 level", level, nomv(o) + ((nomv(n) - nomv(o)) * k) / d);
                    chk("R8 ramp imp", imp_code, 1);
                end else begin
                    chk("R7 status", status, 0);
                    chk("R7 level", level, nomv(n));
                    chk("R8 imp", imp_code, stimp(n));
                end
            end
        end
    endtask

    task automatic settle(input int v);
        @(negedge clk);
        din = 2'(v);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", status, 0);
        chk("R1 level", level, 0);
        chk("R1 imp", imp_code, 0);

        // full sweep of old/new pairs
        for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 4; n++) begin
                settle(o);
                chk("R2 settled level", level, nomv(o));
                din = 2'(n);
                watch(o, n);
            end
        end

        // restart mid-rise: 0 -> 1 then after k=1 go to 0
        settle(0);
        din = 2'b01;
        @(negedge clk);
        @(negedge clk);
        chk("R9 mid-rise level", level, (255 * 1) / RC);
        din = 2'b00;
        watch(1, 0);

        // restart mid-rise toward X from 1: X starts from nominal of 1
        settle(0);
        din = 2'b01;
        @(negedge clk);
        @(negedge clk);
        din = 2'b10;
        watch(1, 2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule